// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block holds the hardware handshake logic of a serial port. On the receive side it compares the receive buffer's current fill level with a programmable watermark. From that comparison it drives the active-low request-to-send pin, which tells the peer to pause before the buffer overflows. When the automatic mode is off, the pin instead follows a software request bit.

On the transmit side, bytes are written into a small queue. A serializer sends them as frames made of one start bit, eight data bits sent LSB first, and one stop bit. When automatic clear-to-send gating is on, the peer's active-low clear-to-send pin is first synchronized. It is then looked at only at the moment the serializer would take the next byte. A frame that has already started always finishes, and the line then stays idle high until the peer allows sending again. Baud-rate generation, the receiver, parity and register decoding are outside the block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 1, `txd` is 1, `txq_empty` is 1 and `txq_full` is 0.
- R2: With `auto_rts_on`=1, `rts_n` is 1 one clock after `rxq_level` >= `rxq_mark`.
- R3: With `auto_rts_on`=1, `rts_n` is 0 one clock after `rxq_level` < `rxq_mark`, so the pin returns as soon as the level drops below the mark.
- R4: With `auto_rts_on`=0, `rts_n` equals the inverse of `rts_sw_req` one clock later, whatever the level and mark are.
- R5: With `auto_cts_on`=1, a frame starts only while the synchronized `cts_n` is 0. While `cts_n` is held at 1, `txd` stays 1 and bytes wait in the queue.
- R6: With `auto_cts_on`=1, if `cts_n` goes to 1 during a frame, that frame completes unchanged. `txd` then stays 1 until `cts_n` returns to 0, after which the next queued byte is sent.
- R7: With `auto_cts_on`=0, queued bytes are sent back to back whatever `cts_n` is. A new frame starts within two clocks after the previous stop bit ends.
- R8: The transmit queue holds 4 bytes. `txq_full` is 1 after 4 writes that are not drained. A write while the queue is full is dropped, so that byte never appears on `txd`. `txq_empty` is 1 again once every byte has been sent.
- R9: The frame layout is start bit 0, then data bits 0 to 7, then stop bit 1. Each bit lasts `TICKS_PER_BIT` (16) `baud_tick` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txq_wr | input | 1 | Write strobe into the transmit queue |
| txq_data | input | 8 | Byte to queue |
| txq_full | output | 1 | Transmit queue holds 4 bytes |
| txq_empty | output | 1 | Transmit queue holds no byte |
| rxq_level | input | 6 | Current receive buffer occupancy |
| rxq_mark | input | 6 | Watermark for request-to-send |
| auto_rts_on | input | 1 | Enables automatic request-to-send |
| auto_cts_on | input | 1 | Enables clear-to-send gating |
| rts_sw_req | input | 1 | Software request, 1 asks for RTS asserted |
| baud_tick | input | 1 | One pulse per sixteenth of a bit |
| cts_n | input | 1 | Peer clear-to-send, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| txd | output | 1 | Serial data out, idle high |

## Verification
`rts_n` is a register, so a change of level, mark, enable or software bit shows on the pin after exactly one rising edge. The bench applies each table vector at a falling edge and samples at the next falling edge. A change on `cts_n` passes through two synchronizer flops before the load decision, so the first start bit can come three or four clocks later. Because of this, frame checks never use a fixed start cycle. They wait for the falling start edge, with a timeout that is tight for the back-to-back case and long for the blocked case. With one tick per clock, each bit is then sampled eight clocks into its sixteen-clock cell.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
   typedef enum logic {
      TXS_IDLE = 1'b0,
      TXS_SEND = 1'b1
   } txs_e;

   // start bit plus stop bit around the data field
   localparam int unsigned FRAME_OVERHEAD = 2;

   function automatic int unsigned width_of(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/fc_tx_fifo.sv
module fc_tx_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty
);
   localparam int unsigned AW = uart_fc_pkg::width_of(DEPTH);

   initial begin : param_check
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("fc_tx_fifo: DEPTH must be a power of two >= 2");
      assert (DATA_W >= 1) else $error("fc_tx_fifo: DATA_W must be >= 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0]       wptr, rptr;
   logic              push, pop;

   assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty   = (wptr == rptr);
   assign push    = wr_en && !full;
   assign pop     = rd_en && !empty;
   assign rd_data = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr[AW-1:0]] <= wr_data;
   end

   // a write against a full queue leaves the write pointer untouched
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en) |=> $stable(wptr));

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/fc_sync.sv
module fc_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin : param_check
      assert (STAGES >= 2) else $error("fc_sync: STAGES must be >= 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen #(
   parameter int unsigned CNT_W      = 6,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] mark,
   input  logic             auto_en,
   input  logic             sw_req,
   output logic             rts_n
);
   initial begin : param_check
      assert (CNT_W >= 1) else $error("fc_rts_gen: CNT_W must be >= 1");
   end

   logic hold_off;

   always_comb begin
      if (auto_en) hold_off = (level >= mark);
      else         hold_off = !sw_req;
   end

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rts_n <= 1'b1;
            else        rts_n <= hold_off;
         end

         assert_rts_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (auto_en && level >= mark) |=> rts_n);

         assert_rts_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (auto_en && level < mark) |=> !rts_n);

         assert_rts_manual_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en |=> (rts_n == !$past(sw_req)));
      end else begin : g_comb
         assign rts_n = hold_off;
      end
   endgenerate
endmodule

// File: rtl/fc_tx_shift.sv
module fc_tx_shift #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              have_data,
   input  logic [DATA_W-1:0] data,
   input  logic              gate_en,
   input  logic              clear_ok,
   output logic              take,
   output logic              txd
);
   import uart_fc_pkg::*;

   localparam int unsigned FB = DATA_W + FRAME_OVERHEAD;
   localparam int unsigned TW = width_of(TICKS_PER_BIT);
   localparam int unsigned BW = width_of(FB);
   localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(FB - 1);

   initial begin : param_check
      assert (TICKS_PER_BIT >= 1) else $error("fc_tx_shift: TICKS_PER_BIT must be >= 1");
   end

   txs_e          state;
   logic [FB-1:0] sh;
   logic [TW-1:0] tick_cnt;
   logic [BW-1:0] bit_cnt;
   logic          busy, cell_end;

   assign busy     = (state == TXS_SEND);
   assign take     = !busy && have_data && (!gate_en || clear_ok);
   assign cell_end = baud_tick && (tick_cnt == TICK_LAST);
   assign txd      = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TXS_IDLE;
         sh       <= '1;
         tick_cnt <= '0;
         bit_cnt  <= '0;
      end else if (!busy) begin
         if (take) begin
            sh       <= {1'b1, data, 1'b0};
            state    <= TXS_SEND;
            tick_cnt <= '0;
            bit_cnt  <= '0;
         end
      end else if (baud_tick) begin
         if (cell_end) begin
            tick_cnt <= '0;
            sh       <= {1'b1, sh[FB-1:1]};
            if (bit_cnt == BIT_LAST) begin
               bit_cnt <= '0;
               state   <= TXS_IDLE;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else begin
            tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end

   // no frame may begin while the gate is closed
   assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && gate_en && !clear_ok) |=> !busy);

   // a running frame is never cut short, whatever the clear-to-send line does
   assert_frame_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(cell_end && bit_cnt == BIT_LAST)) |=> busy);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned TXQ_DEPTH       = 4,
   parameter int unsigned OCC_W           = 6,
   parameter int unsigned TICKS_PER_BIT   = 16,
   parameter int unsigned CTS_SYNC_STAGES = 2,
   parameter bit          RTS_REGISTERED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txq_wr,
   input  logic [DATA_W-1:0] txq_data,
   output logic              txq_full,
   output logic              txq_empty,
   input  logic [OCC_W-1:0]  rxq_level,
   input  logic [OCC_W-1:0]  rxq_mark,
   input  logic              auto_rts_on,
   input  logic              auto_cts_on,
   input  logic              rts_sw_req,
   input  logic              baud_tick,
   input  logic              cts_n,
   output logic              rts_n,
   output logic              txd
);
   logic              cts_n_s;
   logic              take;
   logic [DATA_W-1:0] head;

   fc_tx_fifo #(.DATA_W(DATA_W), .DEPTH(TXQ_DEPTH)) i_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (txq_wr),
      .wr_data (txq_data),
      .rd_en   (take),
      .rd_data (head),
      .full    (txq_full),
      .empty   (txq_empty)
   );

   fc_sync #(.STAGES(CTS_SYNC_STAGES), .RESET_VAL(1'b1)) i_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_n),
      .q     (cts_n_s)
   );

   fc_tx_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .have_data (!txq_empty),
      .data      (head),
      .gate_en   (auto_cts_on),
      .clear_ok  (!cts_n_s),
      .take      (take),
      .txd       (txd)
   );

   fc_rts_gen #(.CNT_W(OCC_W), .REGISTERED(RTS_REGISTERED)) i_rts (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (rxq_level),
      .mark    (rxq_mark),
      .auto_en (auto_rts_on),
      .sw_req  (rts_sw_req),
      .rts_n   (rts_n)
   );
endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txq_wr = 1'b0;
   logic [7:0] txq_data = 8'h00;
   logic       txq_full, txq_empty;
   logic [5:0] rxq_level = 6'd0;
   logic [5:0] rxq_mark = 6'd8;
   logic       auto_rts_on = 1'b0;
   logic       auto_cts_on = 1'b0;
   logic       rts_sw_req = 1'b0;
   logic       baud_tick = 1'b1;
   logic       cts_n = 1'b1;
   logic       rts_n, txd;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_flow_ctrl i_uart_flow_ctrl (
      .clk(clk), .rst_n(rst_n), .txq_wr(txq_wr), .txq_data(txq_data),
      .txq_full(txq_full), .txq_empty(txq_empty), .rxq_level(rxq_level),
      .rxq_mark(rxq_mark), .auto_rts_on(auto_rts_on), .auto_cts_on(auto_cts_on),
      .rts_sw_req(rts_sw_req), .baud_tick(baud_tick), .cts_n(cts_n),
      .rts_n(rts_n), .txd(txd)
   );

   // vector: {auto, sw_req, level[5:0], mark[5:0], expected rts_n}
   localparam logic [14:0] VEC [10] = '{
      {1'b1, 1'b0, 6'd7,  6'd8,  1'b0},
      {1'b1, 1'b0, 6'd8,  6'd8,  1'b1},
      {1'b1, 1'b0, 6'd7,  6'd8,  1'b0},
      {1'b1, 1'b0, 6'd9,  6'd8,  1'b1},
      {1'b1, 1'b0, 6'd0,  6'd8,  1'b0},
      {1'b1, 1'b0, 6'd0,  6'd0,  1'b1},
      {1'b0, 1'b1, 6'd20, 6'd8,  1'b0},
      {1'b0, 1'b0, 6'd0,  6'd8,  1'b1},
      {1'b0, 1'b1, 6'd8,  6'd8,  1'b0},
      {1'b1, 1'b1, 6'd63, 6'd63, 1'b1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      txq_wr   = 1'b1;
      txq_data = b;
      @(negedge clk);
      txq_wr   = 1'b0;
   endtask

   // waits up to tmo clocks for a start bit, then samples every bit mid-cell
   task automatic get_frame(input int tmo, output int val, output bit got);
      logic [7:0] d;
      bit         seen = 0;
      got = 0;
      val = -1;
      for (int i = 0; i < tmo && !seen; i++) begin
         @(negedge clk);
         if (txd == 1'b0) seen = 1;
      end
      if (!seen) return;
      got = 1;
      repeat (7) @(negedge clk);
      if (txd != 1'b0) return;
      for (int b = 0; b < 8; b++) begin
         repeat (16) @(negedge clk);
         d[b] = txd;
      end
      repeat (16) @(negedge clk);
      if (txd != 1'b1) return;
      val = int'(d);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1..R9 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int  v;
      bit  g;
      repeat (3) @(negedge clk);

      // R1 reset values
      check(rts_n == 1'b1, "R1 rts_n", rts_n, 1);
      check(txd == 1'b1, "R1 txd", txd, 1);
      check(txq_empty == 1'b1, "R1 empty", txq_empty, 1);
      check(txq_full == 1'b0, "R1 full", txq_full, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 table walk
      for (int k = 0; k < 10; k++) begin
         auto_rts_on = VEC[k][14];
         rts_sw_req  = VEC[k][13];
         rxq_level   = VEC[k][12:7];
         rxq_mark    = VEC[k][6:1];
         @(negedge clk);
         check(rts_n == VEC[k][0],
               VEC[k][14] ? (VEC[k][0] ? "R2 level>=mark" : "R3 level<mark") : "R4 sw bit",
               rts_n, VEC[k][0]);
      end

      // R5 closed gate holds the byte
      auto_cts_on = 1'b1;
      cts_n = 1'b1;
      push(8'h5A);
      get_frame(300, v, g);
      check(!g, "R5 no start while cts_n=1", g, 0);
      check(txq_empty == 1'b0, "R5 byte waits", txq_empty, 0);
      cts_n = 1'b0;
      get_frame(20, v, g);
      check(g && v == 8'h5A, "R5 R9 sent after cts_n=0", v, 8'h5A);

      // R6 deassert during a frame
      push(8'hA5);
      push(8'h3C);
      fork
         get_frame(30, v, g);
         begin
            repeat (40) @(negedge clk);
            cts_n = 1'b1;
         end
      join
      check(g && v == 8'hA5, "R6 frame completes", v, 8'hA5);
      get_frame(400, v, g);
      check(!g, "R6 line stays high", g, 0);
      check(txq_empty == 1'b0, "R6 second byte held", txq_empty, 0);
      cts_n = 1'b0;
      get_frame(20, v, g);
      check(g && v == 8'h3C, "R6 resumes", v, 8'h3C);

      // R8 queue depth and dropped write
      cts_n = 1'b1;
      push(8'h11);
      push(8'h22);
      push(8'h33);
      check(txq_full == 1'b0, "R8 not full at 3", txq_full, 0);
      push(8'h44);
      check(txq_full == 1'b1, "R8 full at 4", txq_full, 1);
      push(8'h55);
      check(txq_full == 1'b1, "R8 still full", txq_full, 1);
      cts_n = 1'b0;
      for (int n = 0; n < 4; n++) begin
         get_frame(30, v, g);
         check(g && v == 8'h11 * (n + 1), "R8 R9 queued order", v, 8'h11 * (n + 1));
      end
      get_frame(400, v, g);
      check(!g, "R8 dropped byte never sent", v, -1);
      check(txq_empty == 1'b1, "R8 empty after drain", txq_empty, 1);

      // R7 both enables off: back to back, cts ignored, rts follows sw bit
      auto_cts_on = 1'b0;
      auto_rts_on = 1'b0;
      cts_n = 1'b1;
      rts_sw_req = 1'b1;
      rxq_level = 6'd40;
      rxq_mark = 6'd2;
      push(8'h81);
      push(8'h7E);
      check(rts_n == 1'b0, "R4 both enables off", rts_n, 0);
      get_frame(10, v, g);
      check(g && v == 8'h81, "R7 first ignores cts", v, 8'h81);
      get_frame(12, v, g);
      check(g && v == 8'h7E, "R7 back to back", v, 8'h7E);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule